// File: doc/BRIEF.md
# Boot ROM Address Window Decoder

This block sits behind the target side of a 32-bit memory bus and decides whether a captured transaction should go to an optional boot ROM. The ROM occupies one window of 1 MB. The upper twelve address bits of that window come from a programmable base register. A request is registered on the cycle its address phase is presented. On the next cycle the decoder raises a one-cycle claim and presents the 20-bit offset of the access inside the window.

Burst read commands (multiple and line) are folded onto the plain memory read code, so the ROM side only ever sees one read command. Every other command, and every memory write, is ignored. Decoding happens only when both the memory-space enable and the ROM decode enable are set. The memory-space enable also opens memory-mapped register space, so it alone is not enough to open the window.

Top module: `rom_window_decoder`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `claim` is 0, `rom_offset` is 0 and `claim_cmd` is 0, whatever `req_valid` carries.
- R2: A qualifying request presented with `req_valid` high on clock edge N drives `claim` high during the cycle after edge N, and for that one cycle only. A cycle whose preceding edge saw `req_valid` low has `claim` at 0.
- R3: The lowest claimed address is `{rom_base, 20'h00000}`. The dword just below it, base minus 4, is not claimed.
- R4: The highest claimed dword is base plus 0xFFFFC. Base plus 0x100000 is not claimed. Address bits 1:0 take no part in the compare, so base plus 0xFFFFF is claimed.
- R5: During a claim, `rom_offset` equals the request address minus the base with bits 1:0 forced to 0. This equals `{req_addr[19:2], 2'b00}`.
- R6: A claimed request with command 4'b1100 (read multiple) or 4'b1110 (read line) gives `claim_cmd` = 4'b0110. A plain read, 4'b0110, also gives 4'b0110.
- R7: A request with any command other than 4'b0110, 4'b1100 or 4'b1110 is never claimed, even when it falls inside the window. This covers memory write 4'b0111, I/O read 4'b0010 and configuration read 4'b1010.
- R8: With `mem_space_en` or `rom_decode_en` at 0, no request is claimed. Whenever `claim` is 0, `rom_offset` and `claim_cmd` are driven to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Address phase present this cycle |
| req_addr | input | 32 | Transaction byte address |
| req_cmd | input | 4 | Transaction command code |
| rom_base | input | 12 | Window base, address bits 31:20 |
| mem_space_en | input | 1 | Memory-space response enable |
| rom_decode_en | input | 1 | Boot ROM window enable |
| claim | output | 1 | Transaction targets the ROM window |
| rom_offset | output | 20 | Dword-aligned offset inside the window |
| claim_cmd | output | 4 | Normalized command, plain read when claimed |

## Verification
The hardest case to reach from the ports is the edge of the window. The three bytes just past the last dword must still hit, while the next dword already misses. A decoder that compared full byte addresses, or that subtracted without checking the borrow, would look correct everywhere else. The stimulus lands on both sides of each edge. It uses a base with the top bits set, where base plus 1 MB wraps around to zero, and one with the low bit set. Requests are sent back to back, so that a claim which lingered past its one cycle would collide with a later expected miss.

// File: rtl/rom_win_pkg.sv
package rom_win_pkg;
   localparam int CMD_W = 4;
   typedef logic [CMD_W-1:0] bus_cmd_t;

   localparam bus_cmd_t CMD_MEM_RD      = 4'b0110;
   localparam bus_cmd_t CMD_MEM_RD_MULT = 4'b1100;
   localparam bus_cmd_t CMD_MEM_RD_LINE = 4'b1110;

   function automatic logic is_rom_read(input bus_cmd_t c);
      return (c == CMD_MEM_RD) || (c == CMD_MEM_RD_MULT) || (c == CMD_MEM_RD_LINE);
   endfunction
endpackage

// File: rtl/rom_phase_reg.sv
module rom_phase_reg
   import rom_win_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [ADDR_W-1:0] in_addr,
   input  bus_cmd_t          in_cmd,
   output logic              ph_valid,
   output logic [ADDR_W-1:0] ph_addr,
   output bus_cmd_t          ph_cmd
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_valid <= 1'b0;
         ph_addr  <= '0;
         ph_cmd   <= '0;
      end else begin
         ph_valid <= in_valid;
         ph_addr  <= in_addr;
         ph_cmd   <= in_cmd;
      end
   end
endmodule

// File: rtl/rom_window_match.sv
module rom_window_match #(
   parameter int ADDR_W      = 32,
   parameter int WIN_LOG2    = 20,
   parameter int ALIGN_BITS  = 2,
   parameter int MATCH_STYLE = 0
) (
   input  logic [ADDR_W-1:0]          ph_addr,
   input  logic [ADDR_W-WIN_LOG2-1:0] base,
   output logic                       hit,
   output logic [WIN_LOG2-1:0]        offset
);
   localparam int DW_W   = ADDR_W - ALIGN_BITS;
   localparam int OFFD_W = WIN_LOG2 - ALIGN_BITS;

   logic [ALIGN_BITS-1:0] unused_low;
   assign unused_low = ph_addr[ALIGN_BITS-1:0];

   generate
      if (MATCH_STYLE == 0) begin : g_slice
         assign hit    = (ph_addr[ADDR_W-1:WIN_LOG2] == base);
         assign offset = {ph_addr[WIN_LOG2-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
      end else begin : g_subtract
         logic [DW_W-1:0] a_dw;
         logic [DW_W-1:0] b_dw;
         logic [DW_W:0]   diff;
         assign a_dw   = ph_addr[ADDR_W-1:ALIGN_BITS];
         assign b_dw   = {base, {OFFD_W{1'b0}}};
         assign diff   = {1'b0, a_dw} - {1'b0, b_dw};
         assign hit    = (diff[DW_W:OFFD_W] == '0);
         assign offset = {diff[OFFD_W-1:0], {ALIGN_BITS{1'b0}}};
      end
   endgenerate
endmodule

// File: rtl/rom_cmd_fold.sv
module rom_cmd_fold
   import rom_win_pkg::*;
#(
   parameter bit FOLD_BURST_READS = 1'b1
) (
   input  bus_cmd_t cmd_in,
   output logic     is_read,
   output bus_cmd_t cmd_out
);
   assign is_read = is_rom_read(cmd_in);

   generate
      if (FOLD_BURST_READS) begin : g_fold
         assign cmd_out = is_read ? CMD_MEM_RD : cmd_in;
      end else begin : g_pass
         assign cmd_out = cmd_in;
      end
   endgenerate
endmodule

// File: rtl/rom_window_decoder.sv
module rom_window_decoder
   import rom_win_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int WIN_LOG2    = 20,
   parameter int ALIGN_BITS  = 2,
   parameter int MATCH_STYLE = 0,
   parameter bit FOLD_BURST  = 1'b1,
   localparam int BASE_W     = ADDR_W - WIN_LOG2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [CMD_W-1:0]    req_cmd,
   input  logic [BASE_W-1:0]   rom_base,
   input  logic                mem_space_en,
   input  logic                rom_decode_en,
   output logic                claim,
   output logic [WIN_LOG2-1:0] rom_offset,
   output logic [CMD_W-1:0]    claim_cmd
);
   generate
      if (WIN_LOG2 >= ADDR_W || WIN_LOG2 <= ALIGN_BITS) begin : g_bad_window
         $error("rom_window_decoder: window size must lie between alignment and address width");
      end
      if (MATCH_STYLE != 0 && MATCH_STYLE != 1) begin : g_bad_style
         $error("rom_window_decoder: MATCH_STYLE must be 0 or 1");
      end
   endgenerate

   logic              ph_valid;
   logic [ADDR_W-1:0] ph_addr;
   bus_cmd_t          ph_cmd;
   logic              win_hit;
   logic [WIN_LOG2-1:0] win_off;
   logic              rd_cmd;
   bus_cmd_t          norm_cmd;
   logic              take;

   rom_phase_reg #(.ADDR_W(ADDR_W)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (req_valid),
      .in_addr  (req_addr),
      .in_cmd   (req_cmd),
      .ph_valid (ph_valid),
      .ph_addr  (ph_addr),
      .ph_cmd   (ph_cmd)
   );

   rom_window_match #(
      .ADDR_W      (ADDR_W),
      .WIN_LOG2    (WIN_LOG2),
      .ALIGN_BITS  (ALIGN_BITS),
      .MATCH_STYLE (MATCH_STYLE)
   ) u_match (
      .ph_addr (ph_addr),
      .base    (rom_base),
      .hit     (win_hit),
      .offset  (win_off)
   );

   rom_cmd_fold #(.FOLD_BURST_READS(FOLD_BURST)) u_fold (
      .cmd_in  (ph_cmd),
      .is_read (rd_cmd),
      .cmd_out (norm_cmd)
   );

   assign take       = ph_valid & mem_space_en & rom_decode_en & rd_cmd & win_hit;
   assign claim      = take;
   assign rom_offset = take ? win_off : '0;
   assign claim_cmd  = take ? norm_cmd : '0;
endmodule

// File: rtl/rom_window_decoder_chk.sv
module rom_window_decoder_chk #(
   parameter int ADDR_W   = 32,
   parameter int WIN_LOG2 = 20,
   localparam int BASE_W  = ADDR_W - WIN_LOG2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic [ADDR_W-1:0]   req_addr,
   input logic [3:0]          req_cmd,
   input logic [BASE_W-1:0]   rom_base,
   input logic                mem_space_en,
   input logic                rom_decode_en,
   input logic                claim,
   input logic [WIN_LOG2-1:0] rom_offset,
   input logic [3:0]          claim_cmd
);
   p_claim_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      claim |-> $past(req_valid));

   p_claim_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
      claim |-> ($past(req_addr[ADDR_W-1:WIN_LOG2]) == rom_base));

   p_offset_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
      claim |-> (rom_offset == {$past(req_addr[WIN_LOG2-1:2]), 2'b00}));

   p_cmd_folded_r6: assert property (@(posedge clk) disable iff (!rst_n)
      claim |-> (claim_cmd == 4'b0110));

   p_read_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
      claim |-> ($past(req_cmd) == 4'b0110 || $past(req_cmd) == 4'b1100 || $past(req_cmd) == 4'b1110));

   p_enables_r8: assert property (@(posedge clk) disable iff (!rst_n)
      claim |-> (mem_space_en && rom_decode_en));

   p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !claim |-> (rom_offset == '0 && claim_cmd == '0));
endmodule

bind rom_window_decoder rom_window_decoder_chk #(
   .ADDR_W   (ADDR_W),
   .WIN_LOG2 (WIN_LOG2)
) u_chk (.*);

// File: tb/sim_rom_window_decoder.sv
module sim_rom_window_decoder;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic [31:0] req_addr;
   logic [3:0]  req_cmd;
   logic [11:0] rom_base;
   logic        mem_space_en;
   logic        rom_decode_en;
   logic        claim;
   logic [19:0] rom_offset;
   logic [3:0]  claim_cmd;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   typedef struct {
      logic        claim;
      logic [19:0] off;
      logic [3:0]  cmd;
      string       tag;
   } exp_t;
   exp_t sb[$];

   always #10 clk = ~clk;

   rom_window_decoder u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_cmd(req_cmd), .rom_base(rom_base), .mem_space_en(mem_space_en),
      .rom_decode_en(rom_decode_en), .claim(claim), .rom_offset(rom_offset),
      .claim_cmd(claim_cmd)
   );

   task automatic check(input string tag, input logic c, input logic [19:0] o,
                        input logic [3:0] m, input logic ec, input logic [19:0] eo,
                        input logic [3:0] em);
      n_checks++;
      if (c !== ec || o !== eo || m !== em) begin
         n_fail++;
         $display("FAIL %s: got claim=%b off=%h cmd=%h, expected claim=%b off=%h cmd=%h",
                  tag, c, o, m, ec, eo, em);
      end
   endtask

   task automatic cfg(input logic [11:0] b, input logic me, input logic re);
      @(negedge clk);
      req_valid     = 1'b0;
      rom_base      = b;
      mem_space_en  = me;
      rom_decode_en = re;
   endtask

   task automatic drive(input logic [31:0] a, input logic [3:0] c, input string tag);
      exp_t e;
      logic rd;
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = a;
      req_cmd   = c;
      rd = (c == 4'b0110) || (c == 4'b1100) || (c == 4'b1110);
      e.claim = mem_space_en && rom_decode_en && rd && (a[31:20] == rom_base);
      e.off   = e.claim ? {a[19:2], 2'b00} : 20'h0;
      e.cmd   = e.claim ? 4'b0110 : 4'h0;
      e.tag   = tag;
      sb.push_back(e);
   endtask

   task automatic idle();
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   always @(posedge clk) begin
      logic v;
      v = req_valid;
      #2;
      if (rst_n === 1'b1 && !done) begin
         if (v) begin
            if (sb.size() == 0) begin
               n_checks++; n_fail++;
               $display("FAIL R2: output cycle with no expected item, got claim=%b expected none", claim);
            end else begin
               exp_t e;
               e = sb.pop_front();
               check(e.tag, claim, rom_offset, claim_cmd, e.claim, e.off, e.cmd);
            end
         end else begin
            check("R2 idle cycle", claim, rom_offset, claim_cmd, 1'b0, 20'h0, 4'h0);
         end
      end
   end

   initial begin
      #(20 * 100000);
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not end, got hang expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      rst_n = 1'b0; req_valid = 1'b1; req_addr = 32'hA5C00000; req_cmd = 4'b0110;
      rom_base = 12'hA5C; mem_space_en = 1'b1; rom_decode_en = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 in reset", claim, rom_offset, claim_cmd, 1'b0, 20'h0, 4'h0);
      req_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", claim, rom_offset, claim_cmd, 1'b0, 20'h0, 4'h0);

      cfg(12'hA5C, 1'b1, 1'b1);
      drive(32'hA5C00000, 4'b0110, "R3 lowest dword");
      idle();
      drive(32'hA5BFFFFC, 4'b0110, "R3 below base");
      drive(32'hA5CFFFFC, 4'b0110, "R4 top dword");
      drive(32'hA5D00000, 4'b0110, "R4 past top");
      drive(32'hA5CFFFFF, 4'b0110, "R4 low bits ignored");
      drive(32'hA5C12347, 4'b0110, "R5 offset aligned");
      drive(32'hA5C12344, 4'b1100, "R6 read multiple folded");
      drive(32'hA5CABCD8, 4'b1110, "R6 read line folded");
      drive(32'hA5C00010, 4'b0111, "R7 write ignored");
      drive(32'hA5C00010, 4'b0010, "R7 io read ignored");
      drive(32'hA5C00010, 4'b1010, "R7 config read ignored");
      drive(32'hA5C00020, 4'b0110, "R2 back to back");
      idle();
      idle();

      cfg(12'hA5C, 1'b0, 1'b1);
      drive(32'hA5C00040, 4'b0110, "R8 memory enable off");
      cfg(12'hA5C, 1'b1, 1'b0);
      drive(32'hA5C00040, 4'b1100, "R8 rom enable off");
      cfg(12'hA5C, 1'b0, 1'b0);
      drive(32'hA5C00040, 4'b1110, "R8 both off");

      cfg(12'hFFF, 1'b1, 1'b1);
      drive(32'hFFFFFFFC, 4'b0110, "R4 top of address space");
      drive(32'hFFF00000, 4'b1110, "R3 base at top");
      drive(32'hFFEFFFFC, 4'b0110, "R3 below top base");
      drive(32'h00000000, 4'b0110, "R4 wrap is outside");
      cfg(12'h001, 1'b1, 1'b1);
      drive(32'h0010ABC8, 4'b1100, "R5 odd base offset");
      drive(32'h0000FFFC, 4'b0110, "R3 below odd base");
      drive(32'h001FFFFD, 4'b0110, "R4 odd base top");
      idle();
      idle();

      n_checks++;
      if (sb.size() != 0) begin
         n_fail++;
         $display("FAIL R2: %0d expected items left, expected 0", sb.size());
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule